// File: doc/BRIEF.md
# Ganged Port Power and Overcurrent Guard

This block owns the single power switch that feeds all four downstream ports of a hub, and the one overcurrent flag that covers them together. Host requests arrive as one-cycle strobes: turn power on for a selected port, turn it off for a selected port, or acknowledge the overcurrent change flag. Because the switch is shared, it stays on while any port is still marked powered. It turns off when the last marked port is cleared, or at once when a qualified overcurrent appears.

The overcurrent input is active low and asynchronous. It passes through a two-stage synchronizer, and a run-length filter then requires a set number of consecutive low samples before the fault counts. A qualified fault raises the status bit, latches the change bit and drops the switch enable. It also latches a trip state that holds power off and makes the status LED blink. The trip ends when the host clears every port or when the hub is enumerated again.

The LED is lit while the hub is enumerated and not suspended. During a trip it alternates dark and lit phases of a parameterized length, starting dark.

Top module: `gang_power_guard`

## Requirements
- R1: While reset is asserted and right after it is released, `pwrEn`, `ocStatus` and `ocChange` are 0 and no port is marked powered.
- R2: A power-on strobe for port `portSel` (0 to NUM_PORTS-1) marks that port, and `pwrEn` is 1 from the next clock on, provided no fault or trip is present.
- R3: A power-off strobe unmarks one port. `pwrEn` stays 1 while at least one other port is marked and falls on the clock that unmarks the last one.
- R4: `ocStatus` rises only after `ocN` has been low for FILT_CYCLES consecutive samples after the two synchronizer stages. That is FILT_CYCLES+2 clocks after a clean falling input. Shorter low pulses leave `ocStatus` and `pwrEn` unchanged, and `ocStatus` falls once the synchronized input reads high.
- R5: `pwrEn` is 0 in the same cycle that `ocStatus` is 1.
- R6: A qualified fault sets `ocChange` one clock after `ocStatus` rises. The bit stays 1 after the fault ends until a `clrOcChangeStb` pulse, which clears it on the next clock.
- R7: After a fault the trip holds `pwrEn` at 0, even if new power-on strobes arrive. The trip ends on the clock after every port is unmarked or after a rising edge of `enumerated`, and power then returns for ports still marked.
- R8: With no trip, `statLed` equals `enumerated` and not `suspend`.
- R9: During a trip `statLed` is dark for the first BLINK_HALF clocks, then toggles every BLINK_HALF clocks, while enumerated and not suspended.
- R10: When the trip ends, blinking stops and `statLed` returns to the steady behaviour of R8.
- R11: If a power-on and a power-off strobe name the same port in the same cycle, the port ends up unmarked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ocN | input | 1 | Asynchronous overcurrent flag, low means fault |
| setPowerStb | input | 1 | Host request: mark port `portSel` powered |
| clrPowerStb | input | 1 | Host request: unmark port `portSel` |
| portSel | input | IDX_W | Port index for the power strobes |
| clrOcChangeStb | input | 1 | Host acknowledge of the overcurrent change flag |
| enumerated | input | 1 | Hub is configured by the host |
| suspend | input | 1 | Hub is in suspend |
| pwrEn | output | 1 | Enable for the shared port power switch |
| ocStatus | output | 1 | Current qualified overcurrent condition |
| ocChange | output | 1 | Sticky overcurrent change flag |
| statLed | output | 1 | Status LED drive, steady or blinking |

## Verification
A port mask that has drifted shows up as `pwrEn` wrong on the clock after the strobe that should have set or cleared it. A filter counter that is off by one moves the `ocStatus` rise by a cycle against the FILT_CYCLES+2 latency. A trip flag stuck at either value shows within one clock as `pwrEn` back on while tripped, or as a missing dark phase on `statLed`. Errors in the blink counter appear within BLINK_HALF clocks as a toggle at the wrong cycle. The reference model runs alongside the design and compares all four outputs on every clock, so each of these shows in the first cycle it affects.

// File: rtl/gpg_pkg.sv
package gpg_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic setReq;    // mark the selected port powered
    logic clrReq;    // unmark the selected port
    logic blinkRun;  // blink timer is allowed to run
  } gpgStb_t;
endpackage

// File: rtl/gpg_datapath.sv
module gpg_datapath
  import gpg_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int FILT_CYCLES = 16,
  parameter int BLINK_HALF  = 3000000,
  parameter int IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ocN,
  input  gpgStb_t          stb,
  input  logic [IDX_W-1:0] portIdx,
  output logic             ocActive,
  output logic             maskAny,
  output logic             blinkPhase
);
  localparam int RUN_W = $clog2(FILT_CYCLES + 1);
  localparam int BLK_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

  // Two-stage synchronizer, reset to the no-fault level.
  logic [1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], ocN};
  end

  // Run-length filter on the synchronized low level.
  logic [RUN_W-1:0] lowRun, runNext;
  always_comb begin
    if (syncQ[1])                              runNext = '0;
    else if (lowRun == RUN_W'(FILT_CYCLES))    runNext = lowRun;
    else                                       runNext = lowRun + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun   <= '0;
      ocActive <= 1'b0;
    end else begin
      lowRun   <= runNext;
      ocActive <= (runNext == RUN_W'(FILT_CYCLES));
    end
  end

  // Per-port power marks; clear wins over set on the same port.
  logic [NUM_PORTS-1:0] portMask, setOH, clrOH;
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign setOH[g] = stb.setReq && (portIdx == IDX_W'(g));
    assign clrOH[g] = stb.clrReq && (portIdx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portMask <= '0;
    else       portMask <= (portMask | setOH) & ~clrOH;
  end
  assign maskAny = |portMask;

  // Blink timer: idle and dark unless enabled.
  logic [BLK_W-1:0] blinkCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else if (!stb.blinkRun) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else if (blinkCnt == BLK_W'(BLINK_HALF - 1)) begin
      blinkCnt   <= '0;
      blinkPhase <= ~blinkPhase;
    end else begin
      blinkCnt   <= blinkCnt + BLK_W'(1);
    end
  end

  // R11 / R3: a clear request leaves the addressed port unmarked.
  p_port_cleared_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrReq && int'(portIdx) < NUM_PORTS) |=> !portMask[$past(portIdx)]);

  // R4: the filter only qualifies after a low synchronized sample.
  p_filter_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocActive) |-> !$past(syncQ[1]));

  // R9: the blink phase is dark whenever the timer is held idle.
  p_blink_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.blinkRun |=> !blinkPhase);
endmodule

// File: rtl/gpg_control.sv
module gpg_control
  import gpg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    setPowerStb,
  input  logic    clrPowerStb,
  input  logic    clrOcChangeStb,
  input  logic    enumerated,
  input  logic    suspend,
  input  logic    ocActive,
  input  logic    maskAny,
  input  logic    blinkPhase,
  output gpgStb_t stb,
  output logic    pwrEn,
  output logic    ocStatus,
  output logic    ocChange,
  output logic    statLed
);
  logic ocPrev, enumPrev, tripped;
  logic ocRise, enumRise;

  assign ocRise   = ocActive & ~ocPrev;
  assign enumRise = enumerated & ~enumPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocPrev   <= 1'b0;
      enumPrev <= 1'b0;
      tripped  <= 1'b0;
      ocChange <= 1'b0;
    end else begin
      ocPrev   <= ocActive;
      enumPrev <= enumerated;
      if (ocRise)                    tripped <= 1'b1;
      else if (!maskAny || enumRise) tripped <= 1'b0;
      if (ocRise)                    ocChange <= 1'b1;
      else if (clrOcChangeStb)       ocChange <= 1'b0;
    end
  end

  assign stb.setReq   = setPowerStb;
  assign stb.clrReq   = clrPowerStb;
  assign stb.blinkRun = tripped;

  assign pwrEn    = maskAny & ~tripped & ~ocActive;
  assign ocStatus = ocActive;
  assign statLed  = enumerated & ~suspend & (~tripped | blinkPhase);

  // R5: the switch is never enabled while the datapath reports a fault.
  p_off_during_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    ocActive |-> !pwrEn);

  // R6: the change flag survives until the host acknowledges it.
  p_change_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ocChange && !clrOcChangeStb) |=> ocChange);

  // R7: a trip persists while ports remain marked and no re-enumeration.
  p_trip_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tripped && maskAny && !enumRise) |=> tripped);

  // R9: the first cycle of a trip shows a dark LED.
  p_trip_starts_dark_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripped) |-> !statLed);

  // R8: suspend always darkens the LED.
  p_led_suspend_r8: assert property (@(posedge clk) disable iff (!rstN)
    suspend |-> !statLed);
endmodule

// File: rtl/gang_power_guard.sv
module gang_power_guard
  import gpg_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int FILT_CYCLES = 16,
  parameter int BLINK_HALF  = 3000000,
  parameter int IDX_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ocN,
  input  logic             setPowerStb,
  input  logic             clrPowerStb,
  input  logic [IDX_W-1:0] portSel,
  input  logic             clrOcChangeStb,
  input  logic             enumerated,
  input  logic             suspend,
  output logic             pwrEn,
  output logic             ocStatus,
  output logic             ocChange,
  output logic             statLed
);
  gpgStb_t stb;
  logic    ocActive, maskAny, blinkPhase;

  gpg_datapath #(
    .NUM_PORTS  (NUM_PORTS),
    .FILT_CYCLES(FILT_CYCLES),
    .BLINK_HALF (BLINK_HALF),
    .IDX_W      (IDX_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ocN       (ocN),
    .stb       (stb),
    .portIdx   (portSel),
    .ocActive  (ocActive),
    .maskAny   (maskAny),
    .blinkPhase(blinkPhase)
  );

  gpg_control u_control (
    .clk           (clk),
    .rstN          (rstN),
    .setPowerStb   (setPowerStb),
    .clrPowerStb   (clrPowerStb),
    .clrOcChangeStb(clrOcChangeStb),
    .enumerated    (enumerated),
    .suspend       (suspend),
    .ocActive      (ocActive),
    .maskAny       (maskAny),
    .blinkPhase    (blinkPhase),
    .stb           (stb),
    .pwrEn         (pwrEn),
    .ocStatus      (ocStatus),
    .ocChange      (ocChange),
    .statLed       (statLed)
  );
endmodule

// File: tb/gang_power_guard_bench.sv
module gang_power_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILT  = 4;
  localparam int BHALF = 6;

  logic clk = 1'b0, rstN = 1'b0, ocN = 1'b1;
  logic setPowerStb = 1'b0, clrPowerStb = 1'b0, clrOcChangeStb = 1'b0;
  logic [1:0] portSel = 2'd0;
  logic enumerated = 1'b0, suspend = 1'b0;
  logic pwrEn, ocStatus, ocChange, statLed;

  int total = 0, fails = 0, cyc = 0;
  bit finished = 1'b0, modelOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gang_power_guard #(.NUM_PORTS(4), .FILT_CYCLES(FILT), .BLINK_HALF(BHALF)) u_gang_power_guard (
    .clk(clk), .rstN(rstN), .ocN(ocN), .setPowerStb(setPowerStb), .clrPowerStb(clrPowerStb),
    .portSel(portSel), .clrOcChangeStb(clrOcChangeStb), .enumerated(enumerated),
    .suspend(suspend), .pwrEn(pwrEn), .ocStatus(ocStatus), .ocChange(ocChange), .statLed(statLed));

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic chkInt(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model.
  bit mS1, mS2, mOcAct, mOcPrev, mEnumPrev, mTrip, mChg, mPhase;
  int mRun, mBlk;
  bit [3:0] mMask;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mRun = 0; mOcAct = 0; mOcPrev = 0; mEnumPrev = 0;
      mTrip = 0; mChg = 0; mMask = '0; mBlk = 0; mPhase = 0;
    end else begin
      bit rise, eRise, nTrip;
      int run;
      rise  = mOcAct && !mOcPrev;
      eRise = enumerated && !mEnumPrev;
      run   = mS2 ? 0 : ((mRun < FILT) ? mRun + 1 : mRun);
      nTrip = rise ? 1'b1 : ((mMask == 0 || eRise) ? 1'b0 : mTrip);
      if (rise) mChg = 1; else if (clrOcChangeStb) mChg = 0;
      if (!mTrip) begin mBlk = 0; mPhase = 0; end
      else if (mBlk == BHALF - 1) begin mBlk = 0; mPhase = !mPhase; end
      else mBlk = mBlk + 1;
      if (setPowerStb) mMask[portSel] = 1'b1;
      if (clrPowerStb) mMask[portSel] = 1'b0;
      mTrip = nTrip;
      mOcPrev = mOcAct;
      mOcAct = (run >= FILT);
      mRun = run;
      mS2 = mS1; mS1 = ocN;
      mEnumPrev = enumerated;
    end
  end

  always @(negedge clk) begin
    if (modelOn && !finished) begin
      chk("R3 pwrEn model",    pwrEn,    (mMask != 0) && !mTrip && !mOcAct);
      chk("R4 ocStatus model", ocStatus, mOcAct);
      chk("R6 ocChange model", ocChange, mChg);
      chk("R9 statLed model",  statLed,  enumerated && !suspend && (!mTrip || mPhase));
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  task automatic pulse(input bit s, input bit c, input int p);
    @(negedge clk); #1;
    portSel = 2'(p); setPowerStb = s; clrPowerStb = c;
    @(negedge clk); #1;
    setPowerStb = 0; clrPowerStb = 0;
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic fault_until_seen(output int n);
    @(negedge clk); #1; ocN = 0;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); n++;
      if (ocStatus) break;
    end
  endtask

  initial begin
    int n, m, dark;
    waitn(3);
    chk("R1 pwrEn in reset", pwrEn, 1'b0);
    chk("R1 ocStatus in reset", ocStatus, 1'b0);
    @(negedge clk); #1 rstN = 1; modelOn = 1;
    waitn(1);
    chk("R1 pwrEn after reset", pwrEn, 1'b0);
    chk("R1 ocChange after reset", ocChange, 1'b0);
    chk("R8 led dark unenumerated", statLed, 1'b0);
    enumerated = 1; waitn(1);
    chk("R8 led lit when enumerated", statLed, 1'b1);
    suspend = 1; waitn(1);
    chk("R8 led dark in suspend", statLed, 1'b0);
    suspend = 0;

    pulse(1, 0, 2);
    chk("R2 power on after set", pwrEn, 1'b1);
    pulse(1, 0, 0);
    pulse(0, 1, 2);
    chk("R3 power held by port 0", pwrEn, 1'b1);
    pulse(0, 1, 0);
    chk("R3 power off after last clear", pwrEn, 1'b0);
    pulse(1, 1, 1);
    chk("R11 clear wins same port", pwrEn, 1'b0);

    pulse(1, 0, 1);
    chk("R2 power on port 1", pwrEn, 1'b1);
    @(negedge clk); #1 ocN = 0;
    waitn(FILT - 1); ocN = 1;
    waitn(8);
    chk("R4 short glitch ignored status", ocStatus, 1'b0);
    chk("R4 short glitch keeps power", pwrEn, 1'b1);

    fault_until_seen(n);
    chkInt("R4 qualify latency", n, FILT + 2);
    chk("R5 power off with fault", pwrEn, 1'b0);
    @(negedge clk);
    chk("R6 change set", ocChange, 1'b1);
    chk("R9 led starts dark", statLed, 1'b0);
    m = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); m++; if (statLed) break; end
    chkInt("R9 dark phase length", m, BHALF);
    m = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); m++; if (!statLed) break; end
    chkInt("R9 lit phase length", m, BHALF);

    #1 ocN = 1;
    waitn(10);
    chk("R4 status clears", ocStatus, 1'b0);
    chk("R6 change sticky", ocChange, 1'b1);
    chk("R7 power stays off", pwrEn, 1'b0);
    pulse(1, 0, 2);
    chk("R7 set ignored while tripped", pwrEn, 1'b0);
    @(negedge clk); #1 clrOcChangeStb = 1;
    @(negedge clk); #1 clrOcChangeStb = 0;
    chk("R6 change cleared by host", ocChange, 1'b0);
    pulse(0, 1, 1);
    pulse(0, 1, 2);
    waitn(2);
    dark = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!statLed) dark++; end
    chkInt("R10 steady after host removes power", dark, 0);

    pulse(1, 0, 3);
    chk("R2 power on port 3", pwrEn, 1'b1);
    fault_until_seen(n);
    #1 ocN = 1;
    waitn(10);
    chk("R7 power off after second fault", pwrEn, 1'b0);
    enumerated = 0; waitn(2);
    enumerated = 1; waitn(2);
    chk("R7 power back after re-enumeration", pwrEn, 1'b1);
    dark = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!statLed) dark++; end
    chkInt("R10 steady after re-enumeration", dark, 0);

    finish_run();
  end
endmodule